// File: doc/BRIEF.md
# Partitioned Sub-Word SIMD ALU

This block is a 64-bit arithmetic unit that treats each operand as a short vector of narrow integer elements. The element width is chosen with every operation: eight 8-bit, four 16-bit or two 32-bit elements. All elements are processed in parallel. Carries never cross an element boundary.

Lane-wise operations cover the following:
- wrapping add and subtract;
- add and subtract that clamp to the signed or unsigned range instead of wrapping;
- signed and unsigned minimum and maximum;
- equality and greater-than compares that write an all-ones or all-zeros mask into each element.

Two operations leave the lane format. One sums the absolute element differences into a single scalar. The other narrows two operands of 16-bit elements into one result of saturated bytes.

A request is presented with `in_valid`, the opcode, the size select and the two operands. The answer appears on `result` one clock later, flagged by `out_valid`. While no request is presented, the registered result holds its last value.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0. This holds even if `in_valid` is high.
- R2: `out_valid` equals the `in_valid` of the previous clock. When `in_valid` is low, `result` keeps its previous value whatever the other inputs do.
- R3: `esize` selects the element width: 0 = 8 bits, 1 = 16 bits, 2 and 3 = 32 bits. Opcode 0 (wrapping add) and opcode 1 (wrapping subtract) work modulo 2^W per element, with no carry or borrow into the next element.
- R4: Opcode 2 (signed saturating add) and opcode 4 (signed saturating subtract) clamp each element to its two's-complement limits. The limits are 0x7F.. on positive overflow and 0x80.. on negative overflow.
- R5: Opcode 3 (unsigned saturating add) clamps each element to all ones on carry-out. Opcode 5 (unsigned saturating subtract) clamps each element to zero on borrow.
- R6: Opcode 6 gives the signed minimum and opcode 7 the unsigned minimum of each element pair. Opcode 8 gives the signed maximum and opcode 9 the unsigned maximum.
- R7: Each compare writes all ones into an element that satisfies it and zeros otherwise. Opcode 10 is equality, opcode 11 is signed A > B and opcode 12 is unsigned A > B.
- R8: Opcode 13 sums the unsigned absolute differences of all element pairs at the selected width. The sum is zero-extended into the 64-bit result.
- R9: Opcode 14 narrows the four signed 16-bit elements of A into result bytes 0..3 and those of B into bytes 4..7, lowest element first. Each byte is clamped to the signed range -128..127. `esize` is ignored.
- R10: Opcode 15 narrows the same way as opcode 14, but treats the sources as signed and clamps each byte to the unsigned range 0..255. `esize` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| esize | input | 2 | Element width select |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| out_valid | output | 1 | Result strobe, one clock after the request |
| result | output | 64 | Registered result |

## Verification
The vectors sit on element boundaries: 0xFF+0x01 next to a live neighbour, and wrap-around values such as 0x8000 and 0x7FFF. A datapath whose carries leak across elements, or that takes the element width from the wrong size, gives a neighbouring byte off by one.

Saturation cases overflow in both directions. They catch the following faults:
- clamping to the wrong rail;
- clamping signed operations with unsigned rules;
- wrapping when the result should clamp.

The same operand pairs are run through the signed and the unsigned forms of min, max and greater-than. A swapped signedness therefore flips the mask or the chosen element.

The absolute-difference sum is driven to its 33-bit maximum at the 32-bit size, so a truncated accumulator loses the top bit. The narrowing cases include negative inputs for the unsigned pack and values just outside the byte range.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

    localparam int unsigned SIMD_DW = 64;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_ADDSS  = 4'd2,
        OP_ADDUS  = 4'd3,
        OP_SUBSS  = 4'd4,
        OP_SUBUS  = 4'd5,
        OP_MINS   = 4'd6,
        OP_MINU   = 4'd7,
        OP_MAXS   = 4'd8,
        OP_MAXU   = 4'd9,
        OP_CEQ    = 4'd10,
        OP_CGTS   = 4'd11,
        OP_CGTU   = 4'd12,
        OP_SAD    = 4'd13,
        OP_PACKSS = 4'd14,
        OP_PACKUS = 4'd15
    } simd_op_e;

    typedef struct packed {
        logic               vld;
        logic [SIMD_DW-1:0] res;
    } simd_state_t;

endpackage

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] absd
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;
    logic [W:0] dif;
    logic       ovf_add;
    logic       ovf_sub;
    logic       gts;
    logic       gtu;
    logic       eq;

    always_comb begin
        sum     = {1'b0, a} + {1'b0, b};
        dif     = {1'b0, a} - {1'b0, b};
        ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
        gts     = $signed(a) > $signed(b);
        gtu     = a > b;
        eq      = a == b;
        absd    = gtu ? (a - b) : (b - a);
        case (simd_op_e'(op))
            OP_ADD:   res = sum[W-1:0];
            OP_SUB:   res = dif[W-1:0];
            OP_ADDSS: res = ovf_add ? (a[W-1] ? SMIN : SMAX) : sum[W-1:0];
            OP_ADDUS: res = sum[W] ? '1 : sum[W-1:0];
            OP_SUBSS: res = ovf_sub ? (a[W-1] ? SMIN : SMAX) : dif[W-1:0];
            OP_SUBUS: res = dif[W] ? '0 : dif[W-1:0];
            OP_MINS:  res = gts ? b : a;
            OP_MINU:  res = gtu ? b : a;
            OP_MAXS:  res = gts ? a : b;
            OP_MAXU:  res = gtu ? a : b;
            OP_CEQ:   res = {W{eq}};
            OP_CGTS:  res = {W{gts}};
            OP_CGTU:  res = {W{gtu}};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/simd_sad.sv
`timescale 1ns/1ps
module simd_sad #(
    parameter int DW = 64,
    parameter int W  = 8
) (
    input  logic [DW-1:0] absd,
    output logic [DW-1:0] sum
);
    localparam int NL = DW / W;

    always_comb begin
        sum = '0;
        for (int k = 0; k < NL; k++) begin
            sum = sum + DW'(absd[k*W +: W]);
        end
    end
endmodule

// File: rtl/simd_pack.sv
`timescale 1ns/1ps
module simd_pack #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          uns,
    output logic [DW-1:0] res
);
    localparam int NIN  = DW / 16;
    localparam int HALF = DW / 2;

    function automatic logic [7:0] narrow(input logic [15:0] x, input logic u);
        if (u) begin
            if (x[15])            return 8'h00;
            else if (x > 16'd255) return 8'hFF;
            else                  return x[7:0];
        end else begin
            if ($signed(x) > 16'sd127)       return 8'h7F;
            else if ($signed(x) < -16'sd128) return 8'h80;
            else                             return x[7:0];
        end
    endfunction

    for (genvar i = 0; i < NIN; i++) begin : g_narrow
        assign res[i*8 +: 8]        = narrow(a[i*16 +: 16], uns);
        assign res[HALF + i*8 +: 8] = narrow(b[i*16 +: 16], uns);
    end
endmodule

// File: rtl/simd_alu.sv
`timescale 1ns/1ps
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW  = SIMD_DW,
    parameter int NSZ = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic [1:0]    esize,
    input  logic [63:0]   opnd_a,
    input  logic [63:0]   opnd_b,
    output logic          out_valid,
    output logic [63:0]   result
);
    localparam logic [1:0] LAST_SZ = 2'(NSZ - 1);

    logic [NSZ-1:0][DW-1:0] lane_res;
    logic [NSZ-1:0][DW-1:0] sad_res;
    logic [DW-1:0]          pack_res;
    logic [1:0]             sz_idx;
    simd_state_t            st_d, st_q;

    for (genvar gs = 0; gs < NSZ; gs++) begin : g_size
        localparam int W  = 8 << gs;
        localparam int NL = DW / W;
        logic [DW-1:0] r_w;
        logic [DW-1:0] ab_w;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            simd_lane #(.W(W)) u_lane (
                .op   (op),
                .a    (opnd_a[gl*W +: W]),
                .b    (opnd_b[gl*W +: W]),
                .res  (r_w[gl*W +: W]),
                .absd (ab_w[gl*W +: W])
            );
        end
        simd_sad #(.DW(DW), .W(W)) u_sad (
            .absd (ab_w),
            .sum  (sad_res[gs])
        );
        assign lane_res[gs] = r_w;
    end

    simd_pack #(.DW(DW)) u_pack (
        .a   (opnd_a),
        .b   (opnd_b),
        .uns (op == OP_PACKUS),
        .res (pack_res)
    );

    always_comb begin
        sz_idx = (esize > LAST_SZ) ? LAST_SZ : esize;
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            case (simd_op_e'(op))
                OP_SAD:               st_d.res = sad_res[sz_idx];
                OP_PACKSS, OP_PACKUS: st_d.res = pack_res;
                default:              st_d.res = lane_res[sz_idx];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/simd_alu_chk.sv
`timescale 1ns/1ps
module simd_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [1:0]  esize,
    input logic [63:0] opnd_a,
    input logic [63:0] opnd_b,
    input logic        out_valid,
    input logic [63:0] result
);
    function automatic logic mask_ok(input logic [63:0] r, input logic [1:0] es);
        int gb;
        gb = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;
        for (int k = 0; k < 8; k++) begin
            if (r[k*8 +: 8] != 8'h00 && r[k*8 +: 8] != 8'hFF) return 1'b0;
            if (r[k*8 +: 8] != r[(k - (k % gb))*8 +: 8])      return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic bytes_ge(input logic [63:0] r, input logic [63:0] a);
        for (int k = 0; k < 8; k++) begin
            if (r[k*8 +: 8] < a[k*8 +: 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R2
    AST_CMP_IS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd10 && op <= 4'd12) |=> mask_ok(result, $past(esize))); // R7
    AST_SAD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd13) |=> (result[63:33] == '0)); // R8
    AST_USAT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd3 && esize == 2'd0) |=> bytes_ge(result, $past(opnd_a))); // R5

    logic unused_b;
    assign unused_b = ^opnd_b;
endmodule

bind simd_alu simd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .esize     (esize),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  es;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  2'd0, 64'hFF01_7F80_1234_5678, 64'h0101_0180_0101_0101, 64'h0002_8000_1335_5779, 8'd3},  // R3
        '{4'd0,  2'd1, 64'hFF01_7F80_1234_5678, 64'h0101_0180_0101_0101, 64'h0002_8100_1335_5779, 8'd3},  // R3
        '{4'd0,  2'd2, 64'h0000_FFFF_0000_00FF, 64'h0000_0001_0000_0001, 64'h0001_0000_0000_0100, 8'd3},  // R3
        '{4'd1,  2'd0, 64'h0010_807F_0500_0000, 64'h0101_0101_0300_0000, 64'hFF0F_7F7E_0200_0000, 8'd3},  // R3
        '{4'd2,  2'd0, 64'h7F80_50B0_01FF_0000, 64'h01FF_50B0_01FF_0000, 64'h7F80_7F80_02FE_0000, 8'd4},  // R4
        '{4'd2,  2'd1, 64'h7FFF_8000_1000_FFFF, 64'h0001_FFFF_2000_0001, 64'h7FFF_8000_3000_0000, 8'd4},  // R4
        '{4'd3,  2'd0, 64'hFF80_F001_007F_1020, 64'h0180_2001_007F_F0E0, 64'hFFFF_FF02_00FE_FFFF, 8'd5},  // R5
        '{4'd4,  2'd0, 64'h807F_0000_10F0_0500, 64'h01FF_807F_2010_0501, 64'h807F_7F81_F0E0_00FF, 8'd4},  // R4
        '{4'd5,  2'd1, 64'h0005_1000_FFFF_0000, 64'h0006_0FFF_0001_0001, 64'h0000_0001_FFFE_0000, 8'd5},  // R5
        '{4'd5,  2'd2, 64'h0000_0010_8000_0000, 64'h0000_0020_7FFF_FFFF, 64'h0000_0000_0000_0001, 8'd5},  // R5
        '{4'd6,  2'd0, 64'h807F_FF01_0010_2030, 64'h7F80_01FF_0020_1030, 64'h8080_FFFF_0010_1030, 8'd6},  // R6
        '{4'd7,  2'd0, 64'h807F_FF01_0010_2030, 64'h7F80_01FF_0020_1030, 64'h7F7F_0101_0010_1030, 8'd6},  // R6
        '{4'd8,  2'd1, 64'h8000_7FFF_FFFF_0001, 64'h0001_0000_0001_FFFF, 64'h0001_7FFF_0001_0001, 8'd6},  // R6
        '{4'd9,  2'd1, 64'h8000_7FFF_FFFF_0001, 64'h0001_0000_0001_FFFF, 64'h8000_7FFF_FFFF_FFFF, 8'd6},  // R6
        '{4'd10, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, 8'd7},  // R7
        '{4'd10, 2'd1, 64'h1122_3344_5566_7788, 64'h1122_0044_5566_0000, 64'hFFFF_0000_FFFF_0000, 8'd7},  // R7
        '{4'd11, 2'd0, 64'h0180_7FFF_0505_0010, 64'hFF7F_8000_0504_010F, 64'hFF00_FF00_00FF_00FF, 8'd7},  // R7
        '{4'd12, 2'd0, 64'h0180_7FFF_0505_0010, 64'hFF7F_8000_0504_010F, 64'h00FF_00FF_00FF_00FF, 8'd7},  // R7
        '{4'd11, 2'd2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 8'd7},  // R7
        '{4'd13, 2'd0, 64'hFF00_1020_8000_0509, 64'h00FF_2010_0080_0905, 64'h0000_0000_0000_0326, 8'd8},  // R8
        '{4'd13, 2'd1, 64'hFFFF_0000_1234_0010, 64'h0000_FFFF_1234_0020, 64'h0000_0000_0002_000E, 8'd8},  // R8
        '{4'd13, 2'd2, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_FFFF_FFFE, 8'd8},  // R8
        '{4'd14, 2'd2, 64'h0080_FF7F_7FFF_0005, 64'hFFFF_8000_007F_FF80, 64'hFF80_7F80_7F80_7F05, 8'd9},  // R9
        '{4'd15, 2'd0, 64'h0080_FF7F_7FFF_0005, 64'hFFFF_8000_007F_FF80, 64'h0000_7F00_8000_FF05, 8'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  esize = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    simd_alu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .esize     (esize),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic check(input string tag, input logic v_act, input logic v_exp,
                         input logic [63:0] r_act, input logic [63:0] r_exp);
        n_run++;
        if (v_act !== v_exp || r_act !== r_exp) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b result=%h, expected valid=%0b result=%h",
                     tag, v_act, r_act, v_exp, r_exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] o, input logic [1:0] e,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = v; op = o; esize = e; opnd_a = a; opnd_b = b;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with a request presented during reset
        drive(1'b1, 4'd0, 2'd0, 64'd5, 64'd6);
        repeat (2) @(posedge clk);
        #1 check("R1 reset", out_valid, 1'b0, result, 64'd0);
        drive(1'b0, 4'd0, 2'd0, 64'd0, 64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after release", out_valid, 1'b0, result, 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].es, VECS[i].a, VECS[i].b);
            @(posedge clk);
            #1 check($sformatf("R%0d vector %0d", VECS[i].req, i),
                     out_valid, 1'b1, result, VECS[i].exp);
        end

        // R2: idle cycle, changing inputs, result must hold
        drive(1'b0, 4'd0, 2'd0, 64'h1111, 64'h2222);
        @(posedge clk);
        #1 check("R2 idle hold", out_valid, 1'b0, result, VECS[NV-1].exp);
        drive(1'b0, 4'd13, 2'd0, 64'hFF, 64'h00);
        @(posedge clk);
        #1 check("R2 idle hold 2", out_valid, 1'b0, result, VECS[NV-1].exp);

        // R2: single request appears exactly one clock later
        drive(1'b1, 4'd0, 2'd0, 64'd1, 64'd2);
        #1 check("R2 before edge", out_valid, 1'b0, result, VECS[NV-1].exp);
        @(posedge clk);
        #1 check("R2 one cycle later", out_valid, 1'b1, result, 64'd3);

        // R3: size code 3 behaves as 32-bit elements
        drive(1'b1, 4'd0, 2'd3, 64'h0000_FFFF_0000_00FF, 64'h0000_0001_0000_0001);
        @(posedge clk);
        #1 check("R3 esize 3", out_valid, 1'b1, result, 64'h0001_0000_0000_0100);

        // R9: signed pack with a different size code, same bytes
        drive(1'b1, 4'd14, 2'd0, VECS[NV-2].a, VECS[NV-2].b);
        @(posedge clk);
        #1 check("R9 esize ignored", out_valid, 1'b1, result, VECS[NV-2].exp);

        // R10: unsigned pack boundary 0x00FF and 0x0100
        drive(1'b1, 4'd15, 2'd1, 64'h0100_00FF_0000_FFFF, 64'h0000_0000_0000_0000);
        @(posedge clk);
        #1 check("R10 boundary", out_valid, 1'b1, result, 64'h0000_0000_FFFF_0000);

        // R1: reset in the middle of operation clears the register
        drive(1'b0, 4'd0, 2'd0, 64'd0, 64'd0);
        rst_n = 1'b0;
        #1 check("R1 mid-run reset", out_valid, 1'b0, result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule